// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This engine sits beside a NAND flash data bus and sees each word of a page as it passes. While the data words stream, it folds them into a single-error-correct, double-error-detect Hamming code that covers the whole page in one piece. After a program operation the host reads four parity bytes from the register view and writes them into the spare area. During a read, the four stored bytes follow the last data word on the bus. The engine takes them, forms a syndrome and sorts the page into one of four cases: clean, one flipped data bit at a known location, one flipped bit inside the stored parity, or more damage than the code can repair.

The engine never changes the data itself. The host uses the reported word address and bit offset to patch its own buffer. A mode register sets the page size and whether the bus carries bytes or 16-bit words. A control bit restarts the accumulation, so that address cycles seen before the data can be left out. The code is built as two 16-bit halves. One half is taken over the set-bit addresses and the other over their complements. A single data error therefore shows up as a location and its exact complement. A freshly erased page that still carries blank parity appears as a multiple error whose location is all ones.

Top module: `nand_page_ecc`

## Requirements
- R1: The mode register at address 1 holds the page-size select in bits [1:0] and the 16-bit word flag in bit 4, and reads back what was written. The select gives data pages of 512, 1024, 2048 or 4096 bytes for codes 0 to 3. A page then covers the data bytes plus a spare area of one thirty-second of the data size, giving 528, 1056, 2112 or 4224 bytes.
- R2: Each data bit set to one has an address equal to (word index << 4) | bit offset. Register 3 bits [15:0] read the XOR of these addresses over the page, and register 4 bits [15:0] read the XOR of their 16-bit complements. The values refer to the page accumulated so far, while no check result is held.
- R3: Writing a one to bit 0 of register 0 clears both accumulated halves, the page position and the check result. Words seen before that write have no effect on the result.
- R4: On a read, the four bytes that directly follow the data carry the stored code in this order: half-3 low byte, half-3 high byte, half-4 low byte, half-4 high byte. In 16-bit mode they arrive as two words, low byte first. The check result appears on the second rising edge counting the edge that accepts the last stored byte, and not before.
- R5: The status register at address 2 has bit 0 set for any nonzero syndrome, bit 1 set for a single flipped bit inside the stored code, and bit 2 set for an uncorrectable error. Bits 1 and 2 are never set together. After a stored-code error, registers 4:3 read a 32-bit syndrome with only the flipped bit set.
- R6: After a single flipped data bit, status reads 1, register 3 reads the location (word index << 4 | bit offset), and register 4 reads its 16-bit complement. A clean page reads status 0 and both syndromes 0.
- R7: An erased page of all 0xFF bytes that carries blank 0xFF stored bytes reads status 5 with location 0xFFFF.
- R8: In 16-bit mode the word index counts 16-bit words, the bit offset ranges over 0 to 15, and each word is little-endian. In 8-bit mode only bus bits [7:0] are used.
- R9: Bytes after the stored code, up to the end of the page, change neither the code nor the result. The result is kept until the next word after the page end. That word starts a new page and clears the result.
- R10: Stored-code bytes that pass as writes are not checked: status stays 0 and registers 3 and 4 keep the computed code.
- R11: After reset, the mode, status and both code registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| bus_stb | input | 1 | One NAND data word passes this cycle |
| bus_rd | input | 1 | The passing word is a read from the flash (1) or a write (0) |
| bus_data | input | 16 | NAND data bus; bits [7:0] only in 8-bit mode |

## Verification
A table of pages drives the engine in every size setting and both bus widths. The pages include:
- clean pages, which show that the recomputed code matches the stored one;
- single data flips at the first, middle and last word, which confirm the location arithmetic and its complement;
- single flips in each half of the stored code, which separate a damaged code from damaged data;
- two flips in separate words and two flips in the same word, which show that row and column terms cannot hide a double error;
- erased pages in both widths, which give the all-ones location.

Directed runs cover address bytes removed by the restart bit, the exact cycle at which the result appears, spare bytes and program-direction code bytes that leave the state alone, and the clearing at the next page start.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BUS_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int OFF_W     = 4;
  localparam int WADR_W    = 12;
  localparam int LOC_W     = OFF_W + WADR_W;
  localparam int PBYTES    = 4;
  localparam int IDX_W     = $clog2(PBYTES);
  localparam int BASE_PAGE = 512;
  localparam int CNT_W     = 13;

  typedef enum logic [1:0] {
    SYN_CLEAN,
    SYN_DATA1,
    SYN_CODE1,
    SYN_MULTI
  } syn_kind_e;

  typedef struct packed {
    logic mul;
    logic par;
    logic rec;
  } ecc_flags_t;

  // XOR of the addresses of all set bits in one word
  function automatic logic [LOC_W-1:0] word_p_contrib(
    input logic [BUS_W-1:0]  d,
    input logic [WADR_W-1:0] widx
  );
    logic [OFF_W-1:0]  col;
    logic [WADR_W-1:0] row;
    col = '0;
    for (int b = 0; b < BUS_W; b++) begin
      if (d[b]) col = col ^ OFF_W'(b);
    end
    row = (^d) ? widx : '0;
    return {row, col};
  endfunction

  // XOR of the complemented addresses of all set bits in one word
  function automatic logic [LOC_W-1:0] word_n_contrib(
    input logic [BUS_W-1:0]  d,
    input logic [WADR_W-1:0] widx
  );
    return word_p_contrib(d, widx) ^ {LOC_W{^d}};
  endfunction

  function automatic syn_kind_e classify(
    input logic [LOC_W-1:0] sp,
    input logic [LOC_W-1:0] sn
  );
    if ({sp, sn} == '0)                 return SYN_CLEAN;
    else if ((sp ^ sn) == '1)           return SYN_DATA1;
    else if ($countones({sp, sn}) == 1) return SYN_CODE1;
    else                                return SYN_MULTI;
  endfunction
endpackage

// File: rtl/ecc_phase_ctr.sv
module ecc_phase_ctr
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              stb,
  input  logic              wide,
  input  logic [1:0]        size_sel,
  output logic              page_start,
  output logic              in_data,
  output logic              in_code,
  output logic [IDX_W-1:0]  code_idx,
  output logic              last_code,
  output logic [WADR_W-1:0] widx
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] page_bytes;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] code_end;

  always_comb begin
    page_bytes = CNT_W'(BASE_PAGE) << size_sel;
    total      = page_bytes + (page_bytes >> 5);
    step       = wide ? CNT_W'(2) : CNT_W'(1);
    code_end   = page_bytes + CNT_W'(PBYTES);
    in_data    = cnt < page_bytes;
    in_code    = !in_data && (cnt < code_end);
    code_idx   = IDX_W'(cnt - page_bytes);
    last_code  = in_code && ((cnt + step) == code_end);
    page_start = stb && (cnt == '0);
    widx       = wide ? WADR_W'(cnt >> 1) : WADR_W'(cnt);
    nxt        = cnt + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (flush)  cnt <= '0;
    else if (stb)    cnt <= (nxt >= total) ? '0 : nxt;
  end
endmodule

// File: rtl/ecc_par_accum.sv
module ecc_par_accum
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fresh,
  input  logic              acc_en,
  input  logic              wide,
  input  logic [BUS_W-1:0]  data,
  input  logic [WADR_W-1:0] widx,
  output logic [LOC_W-1:0]  p_acc,
  output logic [LOC_W-1:0]  n_acc
);
  logic [BUS_W-1:0] dmask;
  logic [LOC_W-1:0] p_add, n_add, p_base, n_base;

  always_comb begin
    dmask  = wide ? data : {{(BUS_W-BYTE_W){1'b0}}, data[BYTE_W-1:0]};
    p_add  = word_p_contrib(dmask, widx);
    n_add  = word_n_contrib(dmask, widx);
    p_base = fresh ? '0 : p_acc;
    n_base = fresh ? '0 : n_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_acc <= '0;
      n_acc <= '0;
    end else if (flush) begin
      p_acc <= '0;
      n_acc <= '0;
    end else if (acc_en) begin
      p_acc <= p_base ^ p_add;
      n_acc <= n_base ^ n_add;
    end
  end
endmodule

// File: rtl/ecc_syn_eval.sv
module ecc_syn_eval
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fresh,
  input  logic              cap_en,
  input  logic              wide,
  input  logic [IDX_W-1:0]  code_idx,
  input  logic [BUS_W-1:0]  data,
  input  logic              last_rd,
  input  logic [LOC_W-1:0]  p_acc,
  input  logic [LOC_W-1:0]  n_acc,
  output logic              eval_go,
  output logic              chk_valid,
  output ecc_flags_t        flags,
  output logic [LOC_W-1:0]  syn_p,
  output logic [LOC_W-1:0]  syn_n
);
  logic [PBYTES-1:0][BYTE_W-1:0] stored;
  logic [LOC_W-1:0] sp, sn;
  syn_kind_e        kind;
  logic [IDX_W-1:0] hi_idx;

  always_comb begin
    sp     = {stored[1], stored[0]} ^ p_acc;
    sn     = {stored[3], stored[2]} ^ n_acc;
    kind   = classify(sp, sn);
    hi_idx = code_idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored <= '0;
    end else if (cap_en) begin
      stored[code_idx] <= data[BYTE_W-1:0];
      if (wide) stored[hi_idx] <= data[BUS_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      eval_go <= 1'b0;
    else if (flush)  eval_go <= 1'b0;
    else             eval_go <= last_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_valid <= 1'b0;
      flags     <= '0;
      syn_p     <= '0;
      syn_n     <= '0;
    end else if (flush || fresh) begin
      chk_valid <= 1'b0;
      flags     <= '0;
      syn_p     <= '0;
      syn_n     <= '0;
    end else if (eval_go) begin
      chk_valid <= 1'b1;
      flags.rec <= (kind != SYN_CLEAN);
      flags.par <= (kind == SYN_CODE1);
      flags.mul <= (kind == SYN_MULTI);
      syn_p     <= sp;
      syn_n     <= sn;
    end
  end
endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              bus_stb,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_data
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_MODE = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_PAR  = REG_AW'(3);
  localparam logic [REG_AW-1:0] A_NPAR = REG_AW'(4);
  localparam int WIDE_BIT = 4;

  logic [1:0]        size_sel;
  logic              wide;
  logic              clr_evt;
  logic              page_start, in_data, in_code, last_code;
  logic [IDX_W-1:0]  code_idx;
  logic [WADR_W-1:0] widx;
  logic              acc_en, cap_en, last_rd;
  logic [LOC_W-1:0]  p_acc, n_acc, syn_p, syn_n;
  logic              eval_go, chk_valid;
  ecc_flags_t        flags;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[REG_DW-1:WIDE_BIT+1], reg_wdata[WIDE_BIT-1:2]};
  assign clr_evt = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
  assign acc_en  = bus_stb && in_data;
  assign cap_en  = bus_stb && bus_rd && in_code;
  assign last_rd = bus_stb && bus_rd && last_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_sel <= '0;
      wide     <= 1'b0;
    end else if (reg_wr && (reg_addr == A_MODE)) begin
      size_sel <= reg_wdata[1:0];
      wide     <= reg_wdata[WIDE_BIT];
    end
  end

  ecc_phase_ctr u_phase (
    .clk(clk), .rst_n(rst_n), .flush(clr_evt), .stb(bus_stb),
    .wide(wide), .size_sel(size_sel), .page_start(page_start),
    .in_data(in_data), .in_code(in_code), .code_idx(code_idx),
    .last_code(last_code), .widx(widx)
  );

  ecc_par_accum u_accum (
    .clk(clk), .rst_n(rst_n), .flush(clr_evt), .fresh(page_start),
    .acc_en(acc_en), .wide(wide), .data(bus_data), .widx(widx),
    .p_acc(p_acc), .n_acc(n_acc)
  );

  ecc_syn_eval u_eval (
    .clk(clk), .rst_n(rst_n), .flush(clr_evt), .fresh(page_start),
    .cap_en(cap_en), .wide(wide), .code_idx(code_idx), .data(bus_data),
    .last_rd(last_rd), .p_acc(p_acc), .n_acc(n_acc), .eval_go(eval_go),
    .chk_valid(chk_valid), .flags(flags), .syn_p(syn_p), .syn_n(syn_n)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: begin
        reg_rdata[1:0]      = size_sel;
        reg_rdata[WIDE_BIT] = wide;
      end
      A_STAT: reg_rdata[2:0]       = flags;
      A_PAR:  reg_rdata[LOC_W-1:0] = chk_valid ? syn_p : p_acc;
      A_NPAR: reg_rdata[LOC_W-1:0] = chk_valid ? syn_n : n_acc;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk
  import nand_ecc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             clr_evt,
  input logic             page_start,
  input logic             acc_en,
  input logic             eval_go,
  input logic             chk_valid,
  input ecc_flags_t       flags,
  input logic [LOC_W-1:0] p_acc,
  input logic [LOC_W-1:0] n_acc
);
  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags.par && flags.mul));

  // R5
  flags_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags.par || flags.mul) |-> flags.rec);

  // R4
  eval_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_go && !clr_evt && !page_start) |=> chk_valid);

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (p_acc == '0 && n_acc == '0 && !chk_valid));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_start && !clr_evt) |=> !chk_valid);

  // R9
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !clr_evt) |=> ($stable(p_acc) && $stable(n_acc)));
endmodule

bind nand_page_ecc nand_page_ecc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .page_start(page_start),
  .acc_en(acc_en), .eval_go(eval_go), .chk_valid(chk_valid),
  .flags(flags), .p_acc(p_acc), .n_acc(n_acc)
);

// File: tb/nand_page_ecc_tb_top.sv
module nand_page_ecc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        bus_stb;
  logic        bus_rd;
  logic [15:0] bus_data;

  always #10 clk = ~clk;

  nand_page_ecc dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_stb(bus_stb),
    .bus_rd(bus_rd), .bus_data(bus_data)
  );

  // kind: 0 clean, 1 one data flip, 2 code flip, 3 two data flips, 4 erased
  typedef struct packed {
    logic [1:0]  sel;
    logic        wide;
    logic [7:0]  seed;
    logic [2:0]  kind;
    logic [11:0] w1;
    logic [3:0]  b1;
    logic [11:0] w2;
    logic [3:0]  b2;
    logic [4:0]  pbit;
    logic [2:0]  stat;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b0, 8'h35, 3'd0, 12'd0,    4'd0,  12'd0,   4'd0,  5'd0,  3'b000},
    '{2'd0, 1'b0, 8'h5A, 3'd1, 12'd100,  4'd5,  12'd0,   4'd0,  5'd0,  3'b001},
    '{2'd1, 1'b1, 8'h11, 3'd1, 12'd300,  4'd13, 12'd0,   4'd0,  5'd0,  3'b001},
    '{2'd0, 1'b0, 8'h77, 3'd2, 12'd0,    4'd0,  12'd0,   4'd0,  5'd9,  3'b011},
    '{2'd1, 1'b0, 8'h21, 3'd3, 12'd7,    4'd0,  12'd900, 4'd6,  5'd0,  3'b101},
    '{2'd0, 1'b0, 8'h00, 3'd4, 12'd0,    4'd0,  12'd0,   4'd0,  5'd0,  3'b101},
    '{2'd2, 1'b1, 8'h00, 3'd4, 12'd0,    4'd0,  12'd0,   4'd0,  5'd0,  3'b101},
    '{2'd3, 1'b0, 8'h4C, 3'd1, 12'd4095, 4'd7,  12'd0,   4'd0,  5'd0,  3'b001},
    '{2'd0, 1'b1, 8'h93, 3'd3, 12'd20,   4'd2,  12'd20,  4'd11, 5'd0,  3'b101},
    '{2'd2, 1'b0, 8'h0F, 3'd2, 12'd0,    4'd0,  12'd0,   4'd0,  5'd30, 3'b011}
  };

  logic [7:0]  pg [0:4223];
  logic [15:0] exp_p, exp_n;
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_now(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int page_len(input logic [1:0] sel);
    return 512 << sel;
  endfunction

  // address-XOR model, computed per byte
  task automatic model(input int nbytes, input logic wide);
    logic [15:0] a;
    exp_p = '0; exp_n = '0;
    for (int i = 0; i < nbytes; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (pg[i][k]) begin
          a = wide ? 16'(((i / 2) << 4) | ((i % 2) * 8 + k)) : 16'((i << 4) | k);
          exp_p ^= a;
          exp_n ^= ~a;
        end
      end
    end
  endtask

  task automatic flip(input logic wide, input logic [11:0] w, input logic [3:0] b);
    int idx;
    idx = wide ? (2 * int'(w) + int'(b[3])) : int'(w);
    pg[idx][b[2:0]] = ~pg[idx][b[2:0]];
  endtask

  task automatic build(input vec_t v);
    int pl, tot;
    pl = page_len(v.sel);
    tot = pl + pl / 32;
    for (int i = 0; i < tot; i++)
      pg[i] = (v.kind == 3'd4) ? 8'hFF : 8'((i * int'(v.seed)) ^ (i >> 3));
    model(pl, v.wide);
    if (v.kind != 3'd4) begin
      pg[pl]   = exp_p[7:0];
      pg[pl+1] = exp_p[15:8];
      pg[pl+2] = exp_n[7:0];
      pg[pl+3] = exp_n[15:8];
      for (int i = pl + 4; i < tot; i++) pg[i] = 8'(i) ^ 8'h5C;
    end
    if (v.kind == 3'd1 || v.kind == 3'd3) flip(v.wide, v.w1, v.b1);
    if (v.kind == 3'd3) flip(v.wide, v.w2, v.b2);
    if (v.kind == 3'd2) pg[pl + int'(v.pbit) / 8][v.pbit % 8] = ~pg[pl + int'(v.pbit) / 8][v.pbit % 8];
  endtask

  task automatic stream(input int first, input int last, input logic wide, input logic rd);
    int step;
    step = wide ? 2 : 1;
    for (int i = first; i < last; i += step) begin
      if ((i % 37) == 36) begin
        @(negedge clk);
        bus_stb = 1'b0;
      end
      @(negedge clk);
      bus_stb  = 1'b1;
      bus_rd   = rd;
      bus_data = wide ? {pg[i+1], pg[i]} : {8'hA5, pg[i]};
    end
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  task automatic one_word(input logic [15:0] d, input logic rd);
    @(negedge clk);
    bus_stb = 1'b1; bus_rd = rd; bus_data = d;
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] r, p, n;
    logic [15:0] loc;
    string req;
    int pl;
    pl = page_len(v.sel);
    wr_reg(3'd1, {27'd0, v.wide, 2'b00, v.sel});
    wr_reg(3'd0, 32'd1);
    build(v);
    stream(0, pl + pl / 32, v.wide, 1'b1);
    repeat (2) @(negedge clk);
    case (v.kind)
      3'd0: req = "R4";
      3'd1: req = v.wide ? "R8" : "R6";
      3'd4: req = "R7";
      default: req = "R5";
    endcase
    rd_reg(3'd2, r);
    chk(req, "status", r, {29'd0, v.stat});
    rd_reg(3'd3, p);
    rd_reg(3'd4, n);
    loc = {v.w1, v.b1};
    case (v.kind)
      3'd0: chk("R6", "clean syndrome", {n[15:0], p[15:0]}, 32'd0);
      3'd1: begin
        chk(req, "location", p, {16'd0, loc});
        chk("R6", "complement location", n, {16'd0, ~loc});
      end
      3'd2: chk("R5", "code syndrome", {n[15:0], p[15:0]}, 32'd1 << v.pbit);
      3'd4: chk("R7", "erased location", p, 32'h0000FFFF);
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    vec_t v;
    int pl;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_stb = 1'b0; bus_rd = 1'b0; bus_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd_reg(3'd1, r); chk("R11", "mode", r, 32'd0);
    rd_reg(3'd2, r); chk("R11", "status", r, 32'd0);
    rd_reg(3'd3, r); chk("R11", "code low half", r, 32'd0);
    rd_reg(3'd4, r); chk("R11", "code high half", r, 32'd0);

    // R1 mode readback
    wr_reg(3'd1, 32'h13);
    rd_reg(3'd1, r); chk("R1", "mode readback", r, 32'h13);

    for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

    // R2 / R10: program direction, stored bytes corrupted but not checked
    v = '{2'd0, 1'b0, 8'h66, 3'd0, 12'd0, 4'd0, 12'd0, 4'd0, 5'd0, 3'b000};
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd0, 32'd1);
    build(v);
    pg[512] = ~pg[512];
    stream(0, 528, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rd_reg(3'd3, r); chk("R2", "computed code low half", r, {16'd0, exp_p});
    rd_reg(3'd4, r); chk("R2", "computed code high half", r, {16'd0, exp_n});
    rd_reg(3'd2, r); chk("R10", "no check on program", r, 32'd0);

    // R3: address cycles removed by the restart bit
    wr_reg(3'd1, 32'h11);
    wr_reg(3'd0, 32'd1);
    one_word(16'hBEEF, 1'b1);
    one_word(16'h1234, 1'b1);
    one_word(16'h00F3, 1'b1);
    wr_reg(3'd0, 32'd1);
    rd_reg(3'd3, r); chk("R3", "code cleared low", r, 32'd0);
    rd_reg(3'd4, r); chk("R3", "code cleared high", r, 32'd0);
    v = '{2'd1, 1'b1, 8'h3B, 3'd1, 12'd5, 4'd15, 12'd0, 4'd0, 5'd0, 3'b001};
    build(v);
    pl = 1024;
    // R4: result timing
    stream(0, pl + 4, 1'b1, 1'b1);
    rd_now(3'd2, r); chk("R4", "status before update", r, 32'd0);
    rd_reg(3'd2, r); chk("R4", "status after update", r, 32'd1);
    rd_reg(3'd3, r); chk("R3", "location after restart", r, 32'h005F);

    // R9: spare bytes ignored, result kept, cleared at next page
    stream(pl + 4, pl + 32, 1'b1, 1'b1);
    rd_reg(3'd2, r); chk("R9", "status kept over spare", r, 32'd1);
    rd_reg(3'd3, r); chk("R9", "location kept over spare", r, 32'h005F);
    one_word(16'h0001, 1'b1);
    rd_reg(3'd2, r); chk("R9", "status cleared at page start", r, 32'd0);
    rd_reg(3'd3, r); chk("R9", "fresh low half", r, 32'd0);
    rd_reg(3'd4, r); chk("R9", "fresh high half", r, 32'h0000FFFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule